// File: doc/BRIEF.md
# Checked Commit and Rollback Unit

This unit works beside an in-order core that writes its main register file as soon as an instruction completes. Each completed instruction is also handed to an external checker and recorded here in a small queue of unchecked results. Each record holds the destination register, the value written, a pointer into the store buffer, and flags that say whether the instruction writes a register and whether it stores. A separate backup register file, the same size as the main one, holds only state that the checker has approved.

A pass verdict retires the oldest record. Its register result goes into the backup file, and its store, if it has one, is released to memory. A fail verdict flushes the queue, the store buffer and the pipeline in that cycle, and sets a sticky error flag. The unit then holds the core stalled while it copies the backup file into the main register file, one register per cycle. When the copy is done it sends a single redirect to the exception handler base address. Register zero is hard-wired and is never written in either file.

Top module: `chk_commit_unit`

## Requirements
- R1: An enqueue is accepted when `enq_valid_i` is high, `full_o` is low and `stall_o` is low. `full_o` is high exactly when DEPTH records are held. An enqueue offered while full is dropped.
- R2: A pass verdict with a non-empty queue retires the oldest record first, in arrival order. When that record's has-register flag is set, its value is written to its destination in the backup file. No other event writes the backup file.
- R3: On a pass that retires a record with its has-store flag set, `st_release_o` is high in that same cycle and `st_release_ptr_o` equals the record's pointer. It is low on every other retirement.
- R4: A verdict that arrives while the queue is empty has no effect: no release, no flush and no error.
- R5: A fail verdict with a non-empty queue raises `flush_o` for that one cycle and empties the queue.
- R6: From the cycle after a fail, `stall_o` and `restore_we_o` stay high for NREG-1 cycles. During those cycles `restore_addr_o` steps through 1, 2, ..., NREG-1 and `restore_data_o` carries the backup value of that register.
- R7: Register zero is never a restore target and is never written in the backup file, even by a record whose destination is 0.
- R8: In the cycle after the last restore write, `redirect_o` is high for exactly one cycle with `redirect_pc_o` equal to HANDLER_BASE, and `stall_o` is low.
- R9: `err_flag_o` rises in the cycle after a fail and stays high until reset.
- R10: Enqueues and verdicts presented during the restore are ignored.
- R11: After reset the queue is empty, the backup file is all zero, and `full_o`, `stall_o`, `flush_o`, `redirect_o` and `err_flag_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enq_valid_i | input | 1 | A completed instruction is offered |
| enq_has_rd_i | input | 1 | Instruction writes a register |
| enq_has_st_i | input | 1 | Instruction has a store buffer entry |
| enq_rd_i | input | $clog2(NREG) | Destination register |
| enq_data_i | input | XLEN | Register result |
| enq_sb_ptr_i | input | SBW | Store buffer entry pointer |
| full_o | output | 1 | Queue full; core holds completion |
| verdict_valid_i | input | 1 | Checker verdict for the oldest record |
| verdict_pass_i | input | 1 | 1 = pass, 0 = fail |
| st_release_o | output | 1 | Release store to memory |
| st_release_ptr_o | output | SBW | Store buffer entry released |
| flush_o | output | 1 | Flush queue, store buffer and pipeline |
| stall_o | output | 1 | Core held during restore |
| restore_we_o | output | 1 | Main register file write enable |
| restore_addr_o | output | $clog2(NREG) | Main register file write address |
| restore_data_o | output | XLEN | Checked value being restored |
| redirect_o | output | 1 | Inject a jump to the handler |
| redirect_pc_o | output | XLEN | Handler base address |
| err_flag_o | output | 1 | Sticky failed-check status |

## Verification
The assertions check the restore protocol on every cycle. A stall only ever begins right after a flush, a flush is always followed by the error flag and the stall, and restore addresses are never zero and rise by one each cycle. A redirect only follows the last restore write, stores are never released during a flush or a stall, and the error flag never falls. Only the bench scenarios show which values come back. They show that the restored data equals the result of the passed records alone, and that a record with destination zero or with no register write leaves the backup file unchanged. They also show that records still pending at a fail are discarded, and that offers made while full or during a restore are dropped.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_RESTORE = 1'b1} ccu_state_e;
endpackage

// File: rtl/ccu_fifo.sv
module ccu_fifo #(
  parameter int DEPTH = 4,
  parameter int EW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [EW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [EW-1:0] head_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/ccu_backup_rf.sv
module ccu_backup_rf #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] rf_q [NREG];

  assign rdata_o = rf_q[raddr_i];

  // r0 stays zero
  assign rf_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         rf_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))  rf_q[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          verdict_valid_i,
  input  logic          verdict_pass_i,
  input  logic          fifo_empty_i,
  input  logic          head_has_rd_i,
  input  logic          head_has_st_i,
  input  logic [AW-1:0] head_rd_i,
  output logic          pop_o,
  output logic          flush_o,
  output logic          bkp_we_o,
  output logic          st_release_o,
  output logic          run_o,
  output logic [AW-1:0] restore_idx_o,
  output logic          redirect_o,
  output logic          err_o
);
  ccu_state_e    state_q;
  logic [AW-1:0] idx_q;
  logic          verdict_ok;

  assign run_o         = (state_q == ST_RUN);
  assign verdict_ok    = run_o && verdict_valid_i && !fifo_empty_i;
  assign pop_o         = verdict_ok && verdict_pass_i;
  assign flush_o       = verdict_ok && !verdict_pass_i;
  assign bkp_we_o      = pop_o && head_has_rd_i && (head_rd_i != '0);
  assign st_release_o  = pop_o && head_has_st_i;
  assign restore_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      idx_q      <= '0;
      redirect_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      redirect_o <= 1'b0;
      if (flush_o) begin
        state_q <= ST_RESTORE;
        idx_q   <= AW'(1);
        err_o   <= 1'b1;
      end else if (!run_o) begin
        if (idx_q == AW'(NREG - 1)) begin
          state_q    <= ST_RUN;
          idx_q      <= '0;
          redirect_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chk_commit_unit.sv
module chk_commit_unit #(
  parameter int              NREG         = 8,
  parameter int              XLEN         = 16,
  parameter int              DEPTH        = 4,
  parameter int              SBW          = 2,
  parameter logic [XLEN-1:0] HANDLER_BASE = 16'h0100,
  localparam int             AW           = $clog2(NREG),
  localparam int             EW           = 2 + AW + XLEN + SBW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enq_valid_i,
  input  logic            enq_has_rd_i,
  input  logic            enq_has_st_i,
  input  logic [AW-1:0]   enq_rd_i,
  input  logic [XLEN-1:0] enq_data_i,
  input  logic [SBW-1:0]  enq_sb_ptr_i,
  output logic            full_o,
  input  logic            verdict_valid_i,
  input  logic            verdict_pass_i,
  output logic            st_release_o,
  output logic [SBW-1:0]  st_release_ptr_o,
  output logic            flush_o,
  output logic            stall_o,
  output logic            restore_we_o,
  output logic [AW-1:0]   restore_addr_o,
  output logic [XLEN-1:0] restore_data_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            err_flag_o
);
  logic [EW-1:0]   head, enq_word;
  logic            fifo_full, fifo_empty, push, pop, run, bkp_we;
  logic            h_has_rd, h_has_st;
  logic [AW-1:0]   h_rd, ridx;
  logic [XLEN-1:0] h_data;
  logic [SBW-1:0]  h_ptr;

  assign enq_word = {enq_has_rd_i, enq_has_st_i, enq_rd_i, enq_data_i, enq_sb_ptr_i};
  assign {h_has_rd, h_has_st, h_rd, h_data, h_ptr} = head;
  assign push = enq_valid_i && !fifo_full && run;

  ccu_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(enq_word),
    .pop_i(pop), .flush_i(flush_o),
    .head_o(head), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  ccu_ctrl #(.NREG(NREG)) u_ctrl (
    .clk_i, .rst_ni,
    .verdict_valid_i, .verdict_pass_i,
    .fifo_empty_i(fifo_empty),
    .head_has_rd_i(h_has_rd), .head_has_st_i(h_has_st), .head_rd_i(h_rd),
    .pop_o(pop), .flush_o(flush_o), .bkp_we_o(bkp_we),
    .st_release_o(st_release_o), .run_o(run), .restore_idx_o(ridx),
    .redirect_o(redirect_o), .err_o(err_flag_o)
  );

  ccu_backup_rf #(.NREG(NREG), .XLEN(XLEN)) u_bkp (
    .clk_i, .rst_ni,
    .we_i(bkp_we), .waddr_i(h_rd), .wdata_i(h_data),
    .raddr_i(ridx), .rdata_o(restore_data_o)
  );

  assign full_o           = fifo_full;
  assign st_release_ptr_o = h_ptr;
  assign stall_o          = !run;
  assign restore_we_o     = !run;
  assign restore_addr_o   = ridx;
  assign redirect_pc_o    = HANDLER_BASE;
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_o,
  input logic          stall_o,
  input logic          restore_we_o,
  input logic [AW-1:0] restore_addr_o,
  input logic          redirect_o,
  input logic          err_flag_o,
  input logic          st_release_o
);
  // R6
  stall_after_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(flush_o));

  // R9
  flush_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (err_flag_o && stall_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag_o |=> err_flag_o);

  // R7
  no_r0_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_we_o |-> (restore_addr_o != '0));

  // R6
  restore_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_we_o && $past(restore_we_o)) |-> (restore_addr_o == $past(restore_addr_o) + 1'b1));

  // R8
  redirect_after_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> ($past(restore_we_o) && !stall_o));

  // R10
  no_release_in_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_release_o |-> (!stall_o && !flush_o));
endmodule

bind chk_commit_unit ccu_checker #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_o(flush_o), .stall_o(stall_o),
  .restore_we_o(restore_we_o), .restore_addr_o(restore_addr_o),
  .redirect_o(redirect_o), .err_flag_o(err_flag_o), .st_release_o(st_release_o)
);

// File: tb/chk_commit_unit_tb.sv
module chk_commit_unit_tb;
  localparam int NREG = 8, XLEN = 16, DEPTH = 4, SBW = 2, AW = 3;
  localparam logic [XLEN-1:0] HB = 16'h0100;

  logic clk = 0, rst_ni = 0;
  logic enq_valid = 0, enq_has_rd = 0, enq_has_st = 0;
  logic [AW-1:0] enq_rd = '0;
  logic [XLEN-1:0] enq_data = '0;
  logic [SBW-1:0] enq_ptr = '0;
  logic vv = 0, vpass = 0;
  logic full, st_rel, flush, stall, rwe, redir, err;
  logic [SBW-1:0] st_ptr;
  logic [AW-1:0] raddr;
  logic [XLEN-1:0] rdata, rpc;

  int n_chk = 0, n_fail = 0;
  logic [XLEN-1:0] model [NREG];

  always #4 clk = ~clk;

  chk_commit_unit #(.NREG(NREG), .XLEN(XLEN), .DEPTH(DEPTH), .SBW(SBW), .HANDLER_BASE(HB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid), .enq_has_rd_i(enq_has_rd), .enq_has_st_i(enq_has_st),
    .enq_rd_i(enq_rd), .enq_data_i(enq_data), .enq_sb_ptr_i(enq_ptr),
    .full_o(full), .verdict_valid_i(vv), .verdict_pass_i(vpass),
    .st_release_o(st_rel), .st_release_ptr_o(st_ptr), .flush_o(flush),
    .stall_o(stall), .restore_we_o(rwe), .restore_addr_o(raddr),
    .restore_data_o(rdata), .redirect_o(redir), .redirect_pc_o(rpc),
    .err_flag_o(err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    for (int i = 0; i < NREG; i++) model[i] = '0;
  endtask

  task automatic enq(int rd, int data, bit hr, bit hs, int ptr);
    enq_rd = AW'(rd); enq_data = XLEN'(data); enq_has_rd = hr;
    enq_has_st = hs; enq_ptr = SBW'(ptr); enq_valid = 1;
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic pass_chk(string req, bit rel, int ptr);
    vv = 1; vpass = 1;
    #1;
    chk({req, " release"}, int'(st_rel), int'(rel));
    if (rel) chk({req, " release ptr"}, int'(st_ptr), ptr);
    chk({req, " no flush"}, int'(flush), 0);
    @(negedge clk);
    vv = 0;
  endtask

  task automatic fail_restore();
    vv = 1; vpass = 0;
    #1;
    chk("R5 flush pulse", int'(flush), 1);
    @(negedge clk);
    vv = 0;
    chk("R9 err set", int'(err), 1);
    // R10: offers during restore
    enq_valid = 1; enq_has_rd = 1; enq_has_st = 1; enq_rd = 3'd5; enq_data = 16'hdead;
    vv = 1; vpass = 1;
    for (int r = 1; r < NREG; r++) begin
      #1;
      chk("R6 stall", int'(stall), 1);
      chk("R6 restore we", int'(rwe), 1);
      chk("R7 R6 restore addr", int'(raddr), r);
      chk("R6 restore data", int'(rdata), int'(model[r]));
      chk("R10 no release", int'(st_rel), 0);
      chk("R5 single flush", int'(flush), 0);
      @(negedge clk);
    end
    enq_valid = 0; vv = 0;
    #1;
    chk("R8 redirect", int'(redir), 1);
    chk("R8 pc", int'(rpc), int'(HB));
    chk("R8 stall low", int'(stall), 0);
    chk("R8 we low", int'(rwe), 0);
    @(negedge clk);
    chk("R8 single pulse", int'(redir), 0);
    chk("R9 sticky", int'(err), 1);
    // queue empty: verdict does nothing
    pass_chk("R5 R10 queue empty", 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R11
    chk("R11 full", int'(full), 0);
    chk("R11 stall", int'(stall), 0);
    chk("R11 flush", int'(flush), 0);
    chk("R11 redirect", int'(redir), 0);
    chk("R11 err", int'(err), 0);

    // R4: verdicts on an empty queue
    vv = 1; vpass = 0; #1;
    chk("R4 fail empty no flush", int'(flush), 0);
    @(negedge clk); vv = 0;
    chk("R4 no err", int'(err), 0);
    chk("R4 no stall", int'(stall), 0);
    pass_chk("R4 pass empty", 0, 0);

    // R1, R3: fill, overflow drop, ordered retirement
    enq(1, 16'h00a1, 1, 1, 1);
    enq(0, 16'h00b2, 1, 1, 2);
    enq(2, 16'h00c3, 0, 0, 0);
    chk("R1 not full at 3", int'(full), 0);
    enq(3, 16'h00d4, 1, 0, 3);
    chk("R1 full", int'(full), 1);
    enq(4, 16'h00e5, 1, 1, 3);
    chk("R1 still full", int'(full), 1);
    pass_chk("R3 R2 first", 1, 1);
    chk("R1 not full after pop", int'(full), 0);
    pass_chk("R3 R2 second", 1, 2);
    pass_chk("R3 no store", 0, 0);
    pass_chk("R3 no store 2", 0, 0);
    pass_chk("R1 dropped offer", 0, 0);
    model[1] = 16'h00a1; model[3] = 16'h00d4;

    for (int k = 0; k < 3; k++) begin
      // R2: sweep all registers through pass
      for (int r = 0; r < NREG; r++) begin
        int v = (r * 16'h1111) ^ (k * 16'h0f0f) ^ 16'h5a;
        bit hr = ((r + k) % 3) != 0;
        enq(r, v, hr, r[0], r % 4);
        pass_chk("R2 R3 sweep", r[0], r % 4);
        if (hr && r != 0) model[r] = XLEN'(v);
      end
      // pending records discarded at fail
      enq(5, 16'hbeef, 1, 1, 1);
      enq(6, 16'hcafe, 1, 0, 2);
      fail_restore();
      chk("R9 err stays", int'(err), 1);
      do_reset();
      chk("R11 err cleared", int'(err), 0);
      chk("R11 stall cleared", int'(stall), 0);
    end

    // R7: destination zero never lands in backup; reset backup is zero
    enq(0, 16'hffff, 1, 0, 0);
    pass_chk("R7 r0 pass", 0, 0);
    enq(2, 16'h1234, 1, 0, 0);
    fail_restore();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule